// File: doc/BRIEF.md
# Circular Self-Test Path Register

This block is a ring of self-test cells that stand in for the flip-flops of a logic partition, so the partition can test itself. In functional mode every cell is an ordinary D flip-flop that captures its data input from the surrounding logic. In test mode every cell loads its data input XORed with the state of its predecessor in the ring, and the last cell feeds the first. The ring then produces stimulus for the logic and compacts the logic's response at the same time, with the feedback polynomial x^n + 1.

A synchronous master reset puts every cell into a known state before a run, so no unknown value can reach the signature. The primary inputs of the partition pass through a blocking gate that forces them to zero in test mode. A programmable step counter sets the run length to N clocks. When it reaches N the ring freezes and a done flag rises; the frozen ring contents are the signature, which is compared against a value precomputed for a fault-free partition. Dropping test mode clears the counter and returns the cells to plain capture.

Top module: `cstp_ring`

## Requirements
- R1: While rst_ni is low, q_o is all zeros and done_o is low.
- R2: With test_en_i low and mreset_i low, q_o takes the value of func_d_i on every rising clock edge.
- R3: With test_en_i high, mreset_i low and done_o low, each clock edge sets bit i of q_o to func_d_i[i] XOR the old bit i-1, and bit 0 to func_d_i[0] XOR the old bit WIDTH-1 (the ring rotates one place toward the high bit and is XORed with the data).
- R4: mreset_i high clears q_o and the step counter at the next edge, regardless of test_en_i and func_d_i.
- R5: done_o is high exactly when test_en_i is high and cycles_i ring steps have been taken since the counter was last cleared; with cycles_i equal to zero done_o is high at once and no step is taken.
- R6: While done_o is high and mreset_i is low, q_o holds its value and func_d_i has no effect.
- R7: pi_gated_o equals pi_i when test_en_i is low and is all zeros when test_en_i is high.
- R8: Lowering test_en_i clears the step counter, drops done_o in the same cycle, and resumes plain capture at the next edge.
- R9: After a master reset and N steps with a fixed feedback function of q_o and pi_gated_o driving func_d_i, q_o equals the signature a software model of the same ring produces from an all-zero start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master reset of ring and counter |
| test_en_i | input | 1 | Test-mode select |
| cycles_i | input | CNT_W | Number of ring steps in a run, held stable during the run |
| func_d_i | input | WIDTH | Data inputs of the cells, from the logic under test |
| pi_i | input | PI_W | Primary inputs of the partition |
| pi_gated_o | output | PI_W | Primary inputs after the test-mode blocking gate |
| q_o | output | WIDTH | Cell states |
| done_o | output | 1 | Run complete; ring frozen |

## Verification
The hardest situation to reach from the ports is a full closed-loop run, where the cell inputs depend on the cell states themselves, so each step's stimulus is the previous step's response. The bench closes that loop with a combinational feedback function of q_o and pi_gated_o, drives a nonzero pattern on pi_i so that leakage through the blocking gate would change the signature, and compares the frozen ring against a bench model after N steps. It then keeps the feedback changing while done is high to show the freeze, and covers the zero-length run and a master reset issued in the middle of test mode.

// File: rtl/cstp_pkg.sv
package cstp_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC = 2'd0,
    MODE_STEP = 2'd1,
    MODE_HOLD = 2'd2
  } cell_mode_e;
endpackage

// File: rtl/cstp_cell.sv
module cstp_cell
  import cstp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  cell_mode_e mode_i,
  input  logic       d_i,
  input  logic       prev_i,
  output logic       q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else begin
      unique case (mode_i)
        MODE_FUNC: q_o <= d_i;
        MODE_STEP: q_o <= d_i ^ prev_i;
        default:   q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/cstp_ctl.sv
module cstp_ctl
  import cstp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             test_en_i,
  input  logic [CNT_W-1:0] cycles_i,
  output cell_mode_e       mode_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == cycles_i);
  assign done_o = test_en_i && at_end;

  always_comb begin
    if (!test_en_i)  mode_o = MODE_FUNC;
    else if (at_end) mode_o = MODE_HOLD;
    else             mode_o = MODE_STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (mreset_i || !test_en_i) cnt_q <= '0;
    else if (!at_end)                cnt_q <= cnt_q + CNT_ONE;
  end

  // R8: counter restarts whenever test mode is off or master reset is applied
  a_r8_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreset_i || !test_en_i) |=> (cnt_q == '0));

  // R5: counter never steps past the programmed length
  a_r5_cnt_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && test_en_i && at_end && $stable(cycles_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/cstp_in_gate.sv
module cstp_in_gate #(
  parameter int PI_W = 8
) (
  input  logic            block_i,
  input  logic [PI_W-1:0] pi_i,
  output logic [PI_W-1:0] pi_o
);
  assign pi_o = pi_i & {PI_W{~block_i}};
endmodule

// File: rtl/cstp_ring.sv
module cstp_ring
  import cstp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int PI_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             test_en_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic [WIDTH-1:0] func_d_i,
  input  logic [PI_W-1:0]  pi_i,
  output logic [PI_W-1:0]  pi_gated_o,
  output logic [WIDTH-1:0] q_o,
  output logic             done_o
);
  cell_mode_e       mode;
  logic [WIDTH-1:0] ring_q;
  logic [WIDTH-1:0] prev;

  cstp_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mreset_i  (mreset_i),
    .test_en_i (test_en_i),
    .cycles_i  (cycles_i),
    .mode_o    (mode),
    .done_o    (done_o)
  );

  cstp_in_gate #(.PI_W(PI_W)) u_gate (
    .block_i (test_en_i),
    .pi_i    (pi_i),
    .pi_o    (pi_gated_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    // cell 0 closes the ring from the last cell
    if (i == 0) begin : g_wrap
      assign prev[i] = ring_q[WIDTH-1];
    end else begin : g_chain
      assign prev[i] = ring_q[i-1];
    end
    cstp_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (mreset_i),
      .mode_i (mode),
      .d_i    (func_d_i[i]),
      .prev_i (prev[i]),
      .q_o    (ring_q[i])
    );
  end

  assign q_o = ring_q;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && !test_en_i) |=> (q_o == $past(func_d_i)));

  a_r3_ring_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && test_en_i && !done_o) |=>
      (q_o == ($past(func_d_i) ^ {$past(q_o[WIDTH-2:0]), $past(q_o[WIDTH-1])})));

  a_r4_master_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (q_o == '0));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && done_o) |=> $stable(q_o));
endmodule

// File: tb/cstp_ring_test.sv
module cstp_ring_test;
  localparam int W = 8;
  localparam int P = 8;
  localparam int C = 16;
  localparam int NVEC = 7;
  localparam int NRUN = 20;

  // {test_en, func_d, expected q after the edge}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 8'hA5},
    {1'b1, 8'h00, 8'h4B},
    {1'b1, 8'hFF, 8'h69},
    {1'b1, 8'h0F, 8'hDD},
    {1'b0, 8'h3C, 8'h3C},
    {1'b1, 8'h81, 8'hF9},
    {1'b1, 8'h00, 8'hF3}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mreset = 1'b0;
  logic         test_en = 1'b0;
  logic [C-1:0] cycles = '0;
  logic [W-1:0] d_drv = '0;
  logic         fb_on = 1'b0;
  logic [P-1:0] pi = '0;
  logic [P-1:0] pi_g;
  logic [W-1:0] q;
  logic [W-1:0] func_d;
  logic         done;
  int           checks = 0;
  int           errors = 0;
  int           cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] fb(input logic [W-1:0] s, input logic [P-1:0] p);
    return ~(s & {s[3:0], s[7:4]}) ^ p;
  endfunction

  assign func_d = fb_on ? fb(q, pi_g) : d_drv;

  cstp_ring #(.WIDTH(W), .PI_W(P), .CNT_W(C)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mreset_i   (mreset),
    .test_en_i  (test_en),
    .cycles_i   (cycles),
    .func_d_i   (func_d),
    .pi_i       (pi),
    .pi_gated_o (pi_g),
    .q_o        (q),
    .done_o     (done)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] model;
    #1;
    chk("R1 reset q", 16'(q), 16'h0);
    chk("R1 reset done", 16'(done), 16'h0);
    step();
    chk("R1 reset q held", 16'(q), 16'h0);
    rst_n = 1'b1;
    cycles = 16'd100;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      test_en = VEC[i][16];
      d_drv   = VEC[i][15:8];
      step();
      chk(VEC[i][16] ? "R3 ring step" : "R2 capture", 16'(q), 16'(VEC[i][7:0]));
    end

    // R4: master reset in test mode overrides data
    test_en = 1'b1; d_drv = 8'hFF; mreset = 1'b1;
    step();
    chk("R4 master reset in test", 16'(q), 16'h0);
    test_en = 1'b0; d_drv = 8'h77;
    step();
    chk("R4 master reset in normal", 16'(q), 16'h0);
    mreset = 1'b0;

    // R7: input blocking
    pi = 8'hC3; test_en = 1'b0; #1;
    chk("R7 pass in normal", 16'(pi_g), 16'h00C3);
    test_en = 1'b1; #1;
    chk("R7 blocked in test", 16'(pi_g), 16'h0);

    // R9/R5/R6: closed-loop signature run
    test_en = 1'b0; mreset = 1'b1;
    step();
    mreset = 1'b0; fb_on = 1'b1; cycles = 16'(NRUN); test_en = 1'b1;
    model = '0;
    for (int k = 0; k < NRUN; k++) begin
      model = fb(model, '0) ^ {model[W-2:0], model[W-1]};
      step();
      if (k == NRUN - 2) chk("R5 done low before last step", 16'(done), 16'h0);
    end
    chk("R5 done after N steps", 16'(done), 16'h1);
    chk("R9 signature", 16'(q), 16'(model));
    pi = 8'h5A;
    for (int k = 0; k < 5; k++) step();
    chk("R6 frozen signature", 16'(q), 16'(model));
    chk("R6 done held", 16'(done), 16'h1);

    // R8: leaving test mode
    fb_on = 1'b0; d_drv = 8'h96; test_en = 1'b0; #1;
    chk("R8 done drops", 16'(done), 16'h0);
    step();
    chk("R8 capture resumes", 16'(q), 16'h0096);

    // R5: zero-length run
    cycles = '0; test_en = 1'b1; d_drv = 8'h3F; #1;
    chk("R5 zero length done", 16'(done), 16'h1);
    step();
    chk("R6 zero length no step", 16'(q), 16'h0096);

    // R5: short run of 3 steps after test re-entry
    test_en = 1'b0; d_drv = 8'h01;
    step();
    cycles = 16'd3; test_en = 1'b1; d_drv = 8'h00;
    step(); step();
    chk("R5 not done after 2 of 3", 16'(done), 16'h0);
    step();
    chk("R5 done after 3 of 3", 16'(done), 16'h1);
    chk("R3 rotation after 3 steps", 16'(q), 16'h0008);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule